// File: doc/BRIEF.md
# Multi-Channel Sync Start/Hop Controller

This block turns two kinds of synchronisation triggers into per-channel timing events for a bank of receive channels. The first trigger is a software write to a command register. The second is a rising edge on one of several external sync pins. Each trigger can ask for a channel start, a frequency hop, or both. A start leaves the block as a single-cycle pulse on the channel's start output.

A hop is not applied at once. It loads a per-channel holdoff down-counter from the channel's holdoff input. The frequency-update pulse is issued only after that count has run out. A new hop that arrives while a countdown is running restarts the countdown.

Each channel chooses which sync pin it follows, so channels can share one pin, work in pairs, or run independently. A pin acts only while its enable bit is set in the pin configuration register. An optional once-only mode makes each channel act on the first pin sync only and ignore periodic repeats. This mode is re-armed whenever the pin configuration register is written again.

Top module: `syncHopCtrl`

## Requirements
- R1: While `rstN` is low and after reset, `startPulse` and `hopPulse` are zero. The pin configuration register resets to zero, so pin edges have no effect until it is written.
- R2: A write with `regSel`=0 (command register) and `regData[4]`=1 drives `startPulse[c]` high, for exactly the cycle after the write cycle, for every channel c whose `regData[c]` is 1. A command write with `regData[4]`=0 produces no start.
- R3: A command write with `regData[5]`=1 loads holdoff H from `holdoff[c*16 +: 16]` for each selected channel. `hopPulse[c]` is then high for one cycle, exactly H+3 cycles after the write cycle.
- R4: A command write with both bit 4 and bit 5 set produces the start pulse in the next cycle and the hop pulse after the holdoff.
- R5: A holdoff of zero gives the hop pulse 3 cycles after the write cycle, which is the earliest possible slot.
- R6: A hop request arriving while a countdown is active restarts the countdown with the current holdoff value. Only one hop pulse results.
- R7: A rising edge on `syncPin[p]` that first appears in cycle k acts in cycle k+3, through a two-flop synchronizer and edge detect. Falling edges and a level held high do nothing.
- R8: A pin edge acts only when `regSel`=1 configuration bit p (`regData[p]`, p = 0..3) is set.
- R9: Channel c follows pin `pinSel[c*2 +: 2]`. Every channel selecting an active pin acts, and the other channels do not.
- R10: Configuration bit 6 set makes each channel act on the first pin sync only. Bit 6 clear makes every pin sync act. Rewriting the configuration register re-arms the latch.
- R11: For pin syncs, configuration bit 4 requests a start and bit 5 requests a hop. The hop pulse follows H+5 cycles after the pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 = command register, 1 = pin configuration register |
| regData | input | 8 | Write data |
| syncPin | input | 4 | External sync pins (asynchronous) |
| pinSel | input | 8 | Per-channel pin choice, 2 bits per channel |
| holdoff | input | 64 | Per-channel holdoff, 16 bits per channel |
| startPulse | output | 4 | Per-channel start pulse |
| hopPulse | output | 4 | Per-channel frequency-update pulse |

## Verification
Software commands are tried with several channel masks and with start only, hop only and both together. Holdoffs of zero and non-zero are used, and one hop is re-issued mid-countdown, which separates reload from double firing. Pin syncs are driven with channels sharing a pin and with another pin disabled, which separates routing from enable gating. Repeated pulses with the once-only bit set, cleared and re-written show that the latch is per-channel and re-armable.

// File: rtl/shPkg.sv
package shPkg;
  typedef struct packed {
    logic start;
    logic hop;
  } chStrobe_t;

  typedef enum logic {
    REG_CMD = 1'b0,
    REG_PIN = 1'b1
  } regAddr_t;

  localparam int START_BIT = 4;
  localparam int HOP_BIT   = 5;
  localparam int ONCE_BIT  = 6;
endpackage

// File: rtl/syncCtrl.sv
module syncCtrl
  import shPkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_PIN = 4,
  parameter int SEL_W   = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWrEn,
  input  logic                      regSel,
  input  logic [7:0]                regData,
  input  logic [NUM_PIN-1:0]        syncPin,
  input  logic [NUM_CH*SEL_W-1:0]   pinSel,
  output chStrobe_t [NUM_CH-1:0]    ev
);
  regAddr_t addr;
  logic cmdWr, pinWr;
  logic [NUM_PIN-1:0] meta, syncd, prevP, rise;
  logic [6:0] pinCfg;
  logic [NUM_CH-1:0] fired;
  logic unusedTop;

  assign addr   = regAddr_t'(regSel);
  assign cmdWr  = regWrEn && (addr == REG_CMD);
  assign pinWr  = regWrEn && (addr == REG_PIN);
  assign rise   = syncd & ~prevP;
  assign unusedTop = regData[7];

  // two-flop synchronizer plus one stage for edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta  <= '0;
      syncd <= '0;
      prevP <= '0;
    end else begin
      meta  <= syncPin;
      syncd <= meta;
      prevP <= syncd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinCfg <= '0;
    else if (pinWr) pinCfg <= regData[6:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    logic [SEL_W-1:0] selIdx;
    logic pinHit, pinAct, cmdAct;

    assign selIdx = pinSel[c*SEL_W +: SEL_W];
    assign pinHit = rise[selIdx] && pinCfg[selIdx];
    assign pinAct = pinHit && !(pinCfg[ONCE_BIT] && fired[c]);
    assign cmdAct = cmdWr && regData[c];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fired[c]    <= 1'b0;
        ev[c].start <= 1'b0;
        ev[c].hop   <= 1'b0;
      end else begin
        if (pinWr) fired[c] <= 1'b0;
        else if (pinAct) fired[c] <= 1'b1;
        ev[c].start <= (cmdAct && regData[START_BIT]) || (pinAct && pinCfg[START_BIT]);
        ev[c].hop   <= (cmdAct && regData[HOP_BIT])   || (pinAct && pinCfg[HOP_BIT]);
      end
    end
  end
endmodule

// File: rtl/holdoffPath.sv
module holdoffPath
  import shPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int HOLD_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  chStrobe_t [NUM_CH-1:0]   ev,
  input  logic [NUM_CH*HOLD_W-1:0] holdoff,
  output logic [NUM_CH-1:0]        hopPulse
);
  for (genvar c = 0; c < NUM_CH; c++) begin : gCnt
    logic [HOLD_W-1:0] cnt;
    logic active;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt         <= '0;
        active      <= 1'b0;
        hopPulse[c] <= 1'b0;
      end else if (ev[c].hop) begin
        cnt         <= holdoff[c*HOLD_W +: HOLD_W];
        active      <= 1'b1;
        hopPulse[c] <= 1'b0;
      end else if (active) begin
        if (cnt == '0) begin
          active      <= 1'b0;
          hopPulse[c] <= 1'b1;
        end else begin
          cnt         <= cnt - 1'b1;
          hopPulse[c] <= 1'b0;
        end
      end else begin
        hopPulse[c] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/syncHopCtrl.sv
module syncHopCtrl
  import shPkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_PIN = 4,
  parameter int HOLD_W  = 16,
  localparam int SEL_W  = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  logic                     regSel,
  input  logic [7:0]               regData,
  input  logic [NUM_PIN-1:0]       syncPin,
  input  logic [NUM_CH*SEL_W-1:0]  pinSel,
  input  logic [NUM_CH*HOLD_W-1:0] holdoff,
  output logic [NUM_CH-1:0]        startPulse,
  output logic [NUM_CH-1:0]        hopPulse
);
  chStrobe_t [NUM_CH-1:0] ev;

  syncCtrl #(.NUM_CH(NUM_CH), .NUM_PIN(NUM_PIN), .SEL_W(SEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regData(regData), .syncPin(syncPin), .pinSel(pinSel), .ev(ev)
  );

  holdoffPath #(.NUM_CH(NUM_CH), .HOLD_W(HOLD_W)) uPath (
    .clk(clk), .rstN(rstN), .ev(ev), .holdoff(holdoff), .hopPulse(hopPulse)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : gOut
    assign startPulse[c] = ev[c].start;
  end
endmodule

// File: rtl/shChecker.sv
module shChecker #(
  parameter int NUM_CH  = 4,
  parameter int NUM_PIN = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regSel,
  input logic [7:0]        regData,
  input logic [NUM_PIN-1:0] syncPin,
  input logic [NUM_CH-1:0] startPulse,
  input logic [NUM_CH-1:0] hopPulse
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (startPulse == '0 && hopPulse == '0));

  // R2
  cmd_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel && regData[4]) |=>
      ((startPulse & $past(regData[NUM_CH-1:0])) == $past(regData[NUM_CH-1:0])));

  // R6
  single_hop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hopPulse != '0) |=> ((hopPulse & $past(hopPulse)) == '0));

  // R7
  no_spurious_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse != '0) |-> ($past(regWrEn) || ($past(syncPin, 3) != '0)));
endmodule

bind syncHopCtrl shChecker #(.NUM_CH(NUM_CH), .NUM_PIN(NUM_PIN)) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
  .regData(regData), .syncPin(syncPin), .startPulse(startPulse),
  .hopPulse(hopPulse)
);

// File: tb/sim_syncHopCtrl.sv
`timescale 1ns/1ps
module sim_syncHopCtrl;
  logic clk = 0;
  logic rstN = 0;
  logic regWrEn = 0;
  logic regSel = 0;
  logic [7:0] regData = 0;
  logic [3:0] syncPin = 0;
  logic [7:0] pinSel = 0;
  logic [15:0] hold [4];
  logic [63:0] holdoff;
  logic [3:0] startPulse, hopPulse;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign holdoff = {hold[3], hold[2], hold[1], hold[0]};

  syncHopCtrl u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regData(regData), .syncPin(syncPin), .pinSel(pinSel),
    .holdoff(holdoff), .startPulse(startPulse), .hopPulse(hopPulse)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // write presented in cycle k; returns at negedge of cycle k+1
  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk);
    regWrEn = 1; regSel = sel; regData = d;
    @(negedge clk);
    regWrEn = 0; regData = 0;
  endtask

  // watch hop for n cycles, expect single pulse at cycle index idx on channel ch
  task automatic watchHop(string tag, int ch, int n, int idx);
    int seen = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (hopPulse[ch]) begin
        seen++;
        chk({tag, " hop position"}, i, idx);
      end
    end
    chk({tag, " hop count"}, seen, 1);
  endtask

  // drive rising edge on pin p; expect start mask exp at index 3, none else
  task automatic pinEdge(string tag, int p, logic [3:0] exp);
    logic [3:0] other = 0;
    syncPin[p] = 1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (i == 3) chk({tag, " start mask"}, startPulse, exp);
      else other |= startPulse;
    end
    chk({tag, " no extra start"}, other, 0);
    syncPin[p] = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic tReset();
    @(negedge clk);
    chk("R1 start in reset", startPulse, 0);
    chk("R1 hop in reset", hopPulse, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 start after reset", startPulse, 0);
    pinEdge("R1 pin ignored before config", 0, 4'b0000);
  endtask

  task automatic tCmdStart();
    wr(0, 8'h15);
    chk("R2 start mask", startPulse, 4'b0101);
    @(negedge clk);
    chk("R2 start one cycle", startPulse, 0);
    wr(0, 8'h0F);
    chk("R2 no start without bit4", startPulse, 0);
    repeat (6) @(negedge clk);
    chk("R2 no hop without bit5", hopPulse, 0);
  endtask

  task automatic tCmdHop();
    hold[1] = 5;
    wr(0, 8'h22);
    chk("R3 no start on hop only", startPulse, 0);
    watchHop("R3", 1, 12, 7);
  endtask

  task automatic tStartHop();
    hold[2] = 0;
    wr(0, 8'h34);
    chk("R4 start with hop", startPulse, 4'b0100);
    watchHop("R5 zero holdoff", 2, 8, 2);
  endtask

  task automatic tReload();
    hold[0] = 10;
    wr(0, 8'h21);
    repeat (3) @(negedge clk);
    hold[0] = 3;
    wr(0, 8'h21);
    watchHop("R6 reload", 0, 16, 5);
  endtask

  task automatic tPinRoute();
    pinSel = {2'd2, 2'd1, 2'd0, 2'd0};
    wr(1, 8'h13);
    repeat (2) @(negedge clk);
    pinEdge("R9 shared pin0", 0, 4'b0011);
    pinEdge("R7 pin1 routed", 1, 4'b0100);
    pinEdge("R8 disabled pin2", 2, 4'b0000);
  endtask

  task automatic tPinHop();
    hold[2] = 2;
    wr(1, 8'h22);
    repeat (2) @(negedge clk);
    syncPin[1] = 1;
    watchHop("R11 pin hop", 2, 12, 7);
    syncPin[1] = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic tPinOnce();
    wr(1, 8'h51);
    repeat (2) @(negedge clk);
    pinEdge("R10 first acts", 0, 4'b0011);
    pinEdge("R10 repeat ignored", 0, 4'b0000);
    wr(1, 8'h51);
    repeat (2) @(negedge clk);
    pinEdge("R10 rearmed", 0, 4'b0011);
    wr(1, 8'h11);
    repeat (2) @(negedge clk);
    pinEdge("R10 every sync 1", 0, 4'b0011);
    pinEdge("R10 every sync 2", 0, 4'b0011);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) hold[i] = 0;
    repeat (3) @(negedge clk);
    tReset();
    tCmdStart();
    tCmdHop();
    tStartHop();
    tReload();
    tPinRoute();
    tPinHop();
    tPinOnce();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule